// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of N bits (N even, default 6) over several clock cycles. On a start pulse it captures both operands and then retires two multiplier bits per cycle. Each cycle it recodes a three-bit window of the multiplier into a signed digit from {-2, -1, 0, +1, +2}. It adds that multiple of the multiplicand to a running partial sum, then shifts the sum right by two positions. A full product of 2N bits is ready after N/2 steps.

While the block works, a busy flag is raised and further start pulses are ignored. A one-cycle done pulse marks completion, and the registered product holds until the next operation completes. A second output gives a fixed-width N-bit result. It is the upper half of the product, rounded up by the most significant bit of the lower half, so that it loses less than cutting the low half off directly.

Top module: `booth_seq_mul`

## Requirements
- R1: During and directly after reset, busy and done are 0, and product and product_hi are 0.
- R2: For every pair of signed N-bit operands, product equals their exact signed product as a 2N-bit two's-complement value.
- R3: The cycle after start is sampled while idle, busy is 1, and it stays 1 for exactly N/2 cycles. Done is first seen N/2+1 cycles after the start cycle.
- R4: done is high for exactly one cycle, and it rises in the same cycle that busy falls.
- R5: A start pulse seen while busy is ignored. The running operation completes with the operands captured at its own start.
- R6: product and product_hi keep their values from one completion until the next, including through a new start and the busy cycles that follow it.
- R7: The digit for each pair of multiplier bits is x(i-1) + x(i-2) − 2·x(i), with 0 below bit 0. Negative digits use the inverted multiple plus a carry-in of 1. For example, 17 × −9 recodes to −1, +2, −1 (lowest first) and yields −153.
- R8: The most negative operand times itself gives +2^(2N−2) with no overflow.
- R9: product_hi equals product[2N−1:N] plus product[N−1], taken modulo 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand, captured on start |
| multiplier | input | N | Signed multiplier, captured on start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed full product, held between completions |
| product_hi | output | N | Rounded upper N bits of the product |

## Verification
The bench builds the block with the default N = 6. This makes a full sweep of all 4096 signed operand pairs cheap. Each result is checked against integer multiplication, together with the rounded upper half and the latency. The sweep covers the most negative operand on both sides, every recoding window, and both carries of the rounding step. Separate sequences check that a start during busy is ignored and that the product holds across a new operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // Recoded signed digit: magnitude 0, 1 or 2 with a sign flag.
    typedef struct packed {
        logic neg;   // digit is negative
        logic dbl;   // magnitude is 2
        logic zero;  // digit is 0
    } bdigit_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bstate_t;

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
    import booth_mul_pkg::*;
(
    input  logic [2:0] win,   // {x(i), x(i-1), x(i-2)}
    output bdigit_t    dig
);
    always_comb begin
        dig.zero = (win == 3'b000) || (win == 3'b111);
        dig.dbl  = (win == 3'b011) || (win == 3'b100);
        dig.neg  = win[2] && !(win[1] && win[0]);
    end
endmodule

// File: rtl/booth_row_sel.sv
module booth_row_sel
    import booth_mul_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0] mc,
    input  bdigit_t      dig,
    output logic [N+1:0] row,
    output logic         cin
);
    localparam int RW = N + 2;

    logic [RW-1:0] mag;

    always_comb begin
        if (dig.zero)
            mag = '0;
        else if (dig.dbl)
            mag = {mc[N-1], mc, 1'b0};
        else
            mag = {{2{mc[N-1]}}, mc};
        // Negation: inverted row here, the +1 enters as adder carry-in.
        row = dig.neg ? ~mag : mag;
        cin = dig.neg;
    end
endmodule

// File: rtl/booth_fixed_round.sv
module booth_fixed_round #(
    parameter int N = 6
) (
    input  logic [2*N-1:0] prod,
    output logic [N-1:0]   upper
);
    always_comb begin
        upper = prod[2*N-1:N] + {{(N-1){1'b0}}, prod[N-1]};
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_mul_pkg::*;
#(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product,
    output logic [N-1:0]   product_hi
);
    localparam int STEPS = N / 2;
    localparam int HW    = N + 2;            // upper accumulator width
    localparam int SW    = N + 3;            // adder width, no overflow
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        bstate_t        st;
        logic [N-1:0]   mc;
        logic [HW-1:0]  hi;
        logic [N-1:0]   lo;
        logic           qp;
        logic [CW-1:0]  cnt;
        logic           dn;
        logic [2*N-1:0] prod;
    } regs_t;

    regs_t r_d, r_q;

    bdigit_t       dig;
    logic [HW-1:0] row;
    logic          cin;
    logic [SW-1:0] sum;
    logic [HW-1:0] hi_nx;
    logic [N-1:0]  lo_nx;

    booth_digit_enc u_enc (
        .win ({r_q.lo[1], r_q.lo[0], r_q.qp}),
        .dig (dig)
    );

    booth_row_sel #(.N(N)) u_sel (
        .mc  (r_q.mc),
        .dig (dig),
        .row (row),
        .cin (cin)
    );

    always_comb begin
        sum   = {r_q.hi[HW-1], r_q.hi} + {row[HW-1], row} + {{(SW-1){1'b0}}, cin};
        hi_nx = {sum[SW-1], sum[SW-1:2]};
        lo_nx = {sum[1:0], r_q.lo[N-1:2]};

        r_d    = r_q;
        r_d.dn = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_RUN;
                    r_d.mc  = multiplicand;
                    r_d.hi  = '0;
                    r_d.lo  = multiplier;
                    r_d.qp  = 1'b0;
                    r_d.cnt = '0;
                end
            end
            default: begin
                r_d.hi  = hi_nx;
                r_d.lo  = lo_nx;
                r_d.qp  = r_q.lo[1];
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.dn   = 1'b1;
                    r_d.prod = {hi_nx[N-1:0], lo_nx};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '{st: ST_IDLE, default: '0};
        else
            r_q <= r_d;
    end

    booth_fixed_round #(.N(N)) u_round (
        .prod  (r_q.prod),
        .upper (product_hi)
    );

    assign busy    = (r_q.st == ST_RUN);
    assign done    = r_q.dn;
    assign product = r_q.prod;
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int N = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 8'd1;
        else
            run_len <= '0;
    end

    assert_busy_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 8'(N / 2)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_with_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;
    localparam int N = 6;
    localparam int LO = -(1 << (N - 1));
    localparam int HI = (1 << (N - 1)) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplr = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;
    logic [N-1:0]   product_hi;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    booth_seq_mul #(.N(N)) i_booth_seq_mul (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplr),
        .busy         (busy),
        .done         (done),
        .product      (product),
        .product_hi   (product_hi)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_hi(input longint p);
        longint u;
        u = (p >>> N) + ((p >>> (N - 1)) & 1);
        return u & ((1 << N) - 1);
    endfunction

    // Start an operation, wait for done; returns negedges counted to done.
    task automatic run_op(input int a, input int b, output int lat);
        @(negedge clk);
        start = 1'b1;
        mcand = N'(a);
        mplr  = N'(b);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic full_check(input int a, input int b, input string tag);
        int lat;
        longint p;
        run_op(a, b, lat);
        p = longint'(a) * longint'(b);
        check({tag, " product"}, longint'($signed(product)), p);
        check("R9 product_hi", longint'(product_hi), exp_hi(p));
        check("R3 latency", lat, N / 2 + 1);
        check("R4 busy low at done", longint'(busy), 0);
        @(negedge clk);
        check("R4 done width", longint'(done), 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int lat;
        longint held;
        longint held_hi;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", longint'(busy), 0);
        check("R1 done", longint'(done), 0);
        check("R1 product", longint'(product), 0);
        check("R1 product_hi", longint'(product_hi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 product after release", longint'(product), 0);

        // R7 recoding example: 17 x -9
        full_check(17, -9, "R7");
        // R8 most negative squared
        full_check(LO, LO, "R8");
        check("R8 value", longint'($signed(product)), longint'(1) << (2 * N - 2));

        // R5 start during busy ignored
        @(negedge clk);
        start = 1'b1; mcand = N'(7); mplr = N'(-5);
        @(negedge clk);
        check("R3 busy after start", longint'(busy), 1);
        mcand = N'(3); mplr = N'(3);       // start still high while busy
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R5 original operands", longint'($signed(product)), -35);
        check("R5 latency", lat, N / 2 + 1);

        // R6 hold across idle and a new operation
        held = longint'(product);
        held_hi = longint'(product_hi);
        mcand = N'(-1); mplr = N'(9);
        repeat (4) @(negedge clk);
        check("R6 idle hold", longint'(product), held);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 hold in busy", longint'(product), held);
        @(negedge clk);
        check("R6 hi hold in busy", longint'(product_hi), held_hi);
        while (!done) @(negedge clk);
        check("R6 next result", longint'($signed(product)), -9);

        // R2 exhaustive sweep
        for (int a = LO; a <= HI; a++) begin
            for (int b = LO; b <= HI; b++) begin
                full_check(a, b, "R2");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule